// File: doc/BRIEF.md
# Multichannel Mailbox Send Unit

This block is the sending half of an inter-processor mailbox. A host core prepares a 64-bit message in two 32-bit words and picks one of eight target channels. It then writes a trigger register to post the message. The posted message leaves the block as a one-cycle strobe carrying the channel number and the 64-bit payload. The channel is then marked busy. It stays busy until the receiving side acknowledges that channel, and that acknowledge marks the channel as delivered.

A trigger aimed at a channel that is still busy is refused. The refusal raises the channel's overflow flag. The busy, overflow and delivered flags of all channels are packed into one readable status word. The host clears the overflow and delivered flags selectively by writing ones to a clear register.

Three kinds of event are recorded in a pending register, and a mask register decides which of them may drive the single interrupt line:
- block: a refused trigger
- overflow: an overflow flag newly raised
- delivery: an acknowledge that completes a message

Top module: `mbx_send_unit`

## Requirements
- R1: After reset every register reads zero except the mask register at offset 0x1C, which reads 3'b111. No post strobe is issued and the interrupt line is low.
- R2: Writes to offset 0x0 (target channel, bits 7:0), offset 0x4 (payload low word) and offset 0x8 (payload high word) are held and read back at the same offsets.
- R3: A write to offset 0xC with bit 0 set, aimed at an idle channel below 8, does three things on the next cycle. It raises post_valid for exactly one cycle, with post_chan equal to the channel and post_data equal to {high word, low word}. It also sets that channel's busy bit, which is status bit [ch].
- R4: A trigger aimed at a busy channel posts nothing. It sets status bit [8+ch] (overflow) and raises the block event. It raises the overflow event only when that overflow bit was clear before the trigger.
- R5: An acknowledge for a busy channel clears status bit [ch] and sets status bit [16+ch] (delivered) on the same clock edge, and raises the delivery event. An acknowledge for a channel that is not busy changes nothing. This rule still holds when a trigger hits the same busy channel in that cycle: the trigger is refused as in R4.
- R6: A trigger write is ignored, with no post and no state change, in two cases: the target channel register holds 8 or more, or bit 0 of the written data is 0.
- R7: A write to offset 0x10 clears overflow bit [8+ch] for each written data bit [8+ch] that is 1, and delivered bit [16+ch] for each written data bit [16+ch] that is 1. Busy bits are unaffected. A flag set in the same cycle stays set.
- R8: Offset 0x18 reads the pending events: bit 0 block, bit 1 overflow, bit 2 delivery. Offset 0x1C holds the mask in the same bit order, where 1 disables an event. irq is high exactly when some pending event is unmasked.
- R9: A write to offset 0x18 with bit 0 set clears all pending events. An event arriving in the same cycle as that write remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ack_valid | input | 1 | Remote acknowledge strobe |
| ack_chan | input | 3 | Channel being acknowledged |
| post_valid | output | 1 | One-cycle message strobe |
| post_chan | output | 3 | Target channel of the posted message |
| post_data | output | 64 | Posted payload {high, low} |
| irq | output | 1 | Interrupt line |

## Verification
The hardest situations to reach from the ports are the coincidences:
- a refused trigger and an acknowledge for the same busy channel landing on one clock edge
- a pending-clear write meeting a fresh delivery event
- a flag clear racing a flag set

The stimulus tasks drive a register write and a remote acknowledge in the same cycle, so these collisions are forced deliberately. A long pseudo-random phase then mixes writes, triggers and acknowledges against the reference model, which exposes further overlaps.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int OFS_CHAN  = 'h00;
  localparam int OFS_LOW   = 'h04;
  localparam int OFS_HIGH  = 'h08;
  localparam int OFS_TRIG  = 'h0C;
  localparam int OFS_CLR   = 'h10;
  localparam int OFS_STAT  = 'h14;
  localparam int OFS_PEND  = 'h18;
  localparam int OFS_MASK  = 'h1C;

  localparam int FLD_W     = 8;
  localparam int OVF_LSB   = 8;
  localparam int DLV_LSB   = 16;

  typedef struct packed {
    logic dlv;
    logic ovf;
    logic blk;
  } mbx_evt_t;

  function automatic logic [31:0] fn_status_pack(input logic [7:0] busy,
                                                 input logic [7:0] ovf,
                                                 input logic [7:0] dlv);
    return {8'h00, dlv, ovf, busy};
  endfunction

  function automatic logic fn_irq_line(input mbx_evt_t pend, input logic [2:0] mask);
    return |(pend & ~mask);
  endfunction

endpackage

// File: rtl/mbx_host_regs.sv
module mbx_host_regs #(
  parameter int NCH  = 8,
  parameter int ID_W = 8,
  parameter int AW   = 6,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [ID_W-1:0] id_q,
  output logic [DW-1:0]   lo_q,
  output logic [DW-1:0]   hi_q,
  output logic [2:0]      mask_q,
  output logic            trig_fire,
  output logic            trig_bad,
  output logic            fifo_clr_wr,
  output logic            irq_clr_wr,
  output logic            mask_wr
);
  import mbx_pkg::*;

  localparam logic [ID_W-1:0] NCH_ID = ID_W'(NCH);

  logic wr_chan, wr_low, wr_high, wr_trig, id_valid;

  assign wr_chan     = bus_we && (bus_addr == AW'(OFS_CHAN));
  assign wr_low      = bus_we && (bus_addr == AW'(OFS_LOW));
  assign wr_high     = bus_we && (bus_addr == AW'(OFS_HIGH));
  assign wr_trig     = bus_we && (bus_addr == AW'(OFS_TRIG)) && bus_wdata[0];
  assign mask_wr     = bus_we && (bus_addr == AW'(OFS_MASK));
  assign fifo_clr_wr = bus_we && (bus_addr == AW'(OFS_CLR));
  assign irq_clr_wr  = bus_we && (bus_addr == AW'(OFS_PEND)) && bus_wdata[0];
  assign id_valid    = (id_q < NCH_ID);
  assign trig_fire   = wr_trig && id_valid;
  assign trig_bad    = wr_trig && !id_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      mask_q <= 3'b111;
    end else begin
      if (wr_chan) id_q   <= bus_wdata[ID_W-1:0];
      if (wr_low)  lo_q   <= bus_wdata;
      if (wr_high) hi_q   <= bus_wdata;
      if (mask_wr) mask_q <= bus_wdata[2:0];
    end
  end

  // R2
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_chan |=> $stable(id_q));
  // R1
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));

endmodule

// File: rtl/mbx_chan_slot.sv
module mbx_chan_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_hit,
  input  logic ack_hit,
  input  logic clr_ovf,
  input  logic clr_dlv,
  output logic busy_q,
  output logic ovf_q,
  output logic dlv_q,
  output logic post_ok,
  output logic evt_blk,
  output logic evt_ovf,
  output logic evt_dlv
);

  assign post_ok = trig_hit && !busy_q;
  assign evt_blk = trig_hit && busy_q;
  assign evt_ovf = evt_blk && !ovf_q;
  assign evt_dlv = ack_hit && busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ovf_q  <= 1'b0;
      dlv_q  <= 1'b0;
    end else begin
      if (post_ok)      busy_q <= 1'b1;
      else if (evt_dlv) busy_q <= 1'b0;

      if (evt_blk)      ovf_q <= 1'b1;
      else if (clr_ovf) ovf_q <= 1'b0;

      if (evt_dlv)      dlv_q <= 1'b1;
      else if (clr_dlv) dlv_q <= 1'b0;
    end
  end

  // R3
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_hit && !busy_q) |=> busy_q);
  // R4
  overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_hit && busy_q) |=> ovf_q);
  // R5
  deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && busy_q) |=> (!busy_q && dlv_q));
  // R5
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !busy_q && !trig_hit && !clr_dlv) |=> $stable(dlv_q) && !busy_q);
  // R7
  clear_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !(trig_hit && busy_q)) |=> !ovf_q);

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl (
  input  logic             clk,
  input  logic             rst_n,
  input  mbx_pkg::mbx_evt_t evt,
  input  logic             clr_wr,
  input  logic [2:0]       mask,
  input  logic             mask_wr,
  output mbx_pkg::mbx_evt_t pend_q,
  output logic             irq
);
  import mbx_pkg::*;

  mbx_evt_t pend_d;

  always_comb begin
    pend_d = clr_wr ? mbx_evt_t'(3'b000) : pend_q;
    pend_d = pend_d | evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign irq = fn_irq_line(pend_q, mask);

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && (evt == 3'b000)) |=> (pend_q == 3'b000));
  // R9
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.dlv |=> pend_q.dlv);
  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(evt != 3'b000) || $past(mask_wr)));

endmodule

// File: rtl/mbx_send_unit.sv
module mbx_send_unit #(
  parameter int NCH  = 8,
  parameter int ID_W = 8,
  parameter int AW   = 6,
  parameter int DW   = 32,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            ack_valid,
  input  logic [CH_W-1:0] ack_chan,
  output logic            post_valid,
  output logic [CH_W-1:0] post_chan,
  output logic [2*DW-1:0] post_data,
  output logic            irq
);
  import mbx_pkg::*;

  logic [ID_W-1:0] id_q;
  logic [DW-1:0]   lo_q, hi_q;
  logic [2:0]      mask_q;
  logic            trig_fire, trig_bad, fifo_clr_wr, irq_clr_wr, mask_wr;

  logic [NCH-1:0]  busy_v, ovf_v, dlv_v, post_ok_v;
  logic [NCH-1:0]  blk_v, ovfe_v, dlve_v;
  mbx_evt_t        evt, pend_q;
  logic            any_post;

  mbx_host_regs #(.NCH(NCH), .ID_W(ID_W), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .id_q(id_q), .lo_q(lo_q), .hi_q(hi_q),
    .mask_q(mask_q), .trig_fire(trig_fire), .trig_bad(trig_bad),
    .fifo_clr_wr(fifo_clr_wr), .irq_clr_wr(irq_clr_wr), .mask_wr(mask_wr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_slot
    logic trig_hit_i, ack_hit_i;
    assign trig_hit_i = trig_fire && (id_q[CH_W-1:0] == CH_W'(i));
    assign ack_hit_i  = ack_valid && (ack_chan == CH_W'(i));
    mbx_chan_slot u_slot (
      .clk(clk), .rst_n(rst_n),
      .trig_hit(trig_hit_i), .ack_hit(ack_hit_i),
      .clr_ovf(fifo_clr_wr && bus_wdata[OVF_LSB+i]),
      .clr_dlv(fifo_clr_wr && bus_wdata[DLV_LSB+i]),
      .busy_q(busy_v[i]), .ovf_q(ovf_v[i]), .dlv_q(dlv_v[i]),
      .post_ok(post_ok_v[i]), .evt_blk(blk_v[i]),
      .evt_ovf(ovfe_v[i]), .evt_dlv(dlve_v[i])
    );
  end

  assign any_post = |post_ok_v;
  assign evt.blk  = |blk_v;
  assign evt.ovf  = |ovfe_v;
  assign evt.dlv  = |dlve_v;

  mbx_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr_wr(irq_clr_wr),
    .mask(mask_q), .mask_wr(mask_wr), .pend_q(pend_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      post_valid <= 1'b0;
      post_chan  <= '0;
      post_data  <= '0;
    end else begin
      post_valid <= any_post;
      if (any_post) begin
        post_chan <= id_q[CH_W-1:0];
        post_data <= {hi_q, lo_q};
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(OFS_CHAN): bus_rdata = DW'(id_q);
      AW'(OFS_LOW):  bus_rdata = lo_q;
      AW'(OFS_HIGH): bus_rdata = hi_q;
      AW'(OFS_STAT): bus_rdata = fn_status_pack(8'(busy_v), 8'(ovf_v), 8'(dlv_v));
      AW'(OFS_PEND): bus_rdata = DW'(pend_q);
      AW'(OFS_MASK): bus_rdata = DW'(mask_q);
      default:       bus_rdata = '0;
    endcase
  end

  // R3
  single_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(post_ok_v));
  // R3
  post_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid |=> !post_valid || $past(any_post));
  // R6
  bad_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_bad |=> !post_valid);
  // R6
  bad_trig_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_bad && !ack_valid) |=> $stable(busy_v) && $stable(ovf_v));

endmodule

// File: tb/mbx_send_unit_test.sv
module mbx_send_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ack_valid = 1'b0;
  logic [2:0]  ack_chan = '0;
  logic        post_valid;
  logic [2:0]  post_chan;
  logic [63:0] post_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_send_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack_valid(ack_valid),
    .ack_chan(ack_chan), .post_valid(post_valid), .post_chan(post_chan),
    .post_data(post_data), .irq(irq)
  );

  // reference model state
  bit [7:0]  m_id, m_busy, m_ovf, m_dlv;
  bit [31:0] m_lo, m_hi;
  bit [2:0]  m_mask = 3'b111, m_pend;
  bit        m_pv;
  bit [2:0]  m_pc;
  bit [63:0] m_pd;

  always @(posedge clk) begin
    bit [7:0] nb, no, nd, dset;
    bit [2:0] ev;
    bit       clr;
    if (!rst_n) begin
      m_id = 0; m_lo = 0; m_hi = 0; m_mask = 3'b111; m_pend = 0;
      m_busy = 0; m_ovf = 0; m_dlv = 0; m_pv = 0;
    end else begin
      nb = m_busy; no = m_ovf; nd = m_dlv; dset = 0; ev = 0; clr = 0; m_pv = 0;
      if (ack_valid && m_busy[ack_chan]) begin
        nb[ack_chan] = 0; nd[ack_chan] = 1; dset[ack_chan] = 1; ev[2] = 1;
      end
      if (bus_we) begin
        case (bus_addr)
          6'h00: m_id = bus_wdata[7:0];
          6'h04: m_lo = bus_wdata;
          6'h08: m_hi = bus_wdata;
          6'h0C: if (bus_wdata[0] && m_id < 8) begin
                   if (m_busy[m_id]) begin
                     ev[0] = 1;
                     if (!m_ovf[m_id]) ev[1] = 1;
                     no[m_id] = 1;
                   end else begin
                     nb[m_id] = 1; m_pv = 1; m_pc = m_id[2:0]; m_pd = {m_hi, m_lo};
                   end
                 end
          6'h10: begin
                   no = no & ~bus_wdata[15:8];
                   nd = nd & ~(bus_wdata[23:16] & ~dset);
                 end
          6'h18: clr = bus_wdata[0];
          6'h1C: m_mask = bus_wdata[2:0];
          default: ;
        endcase
      end
      m_busy = nb; m_ovf = no; m_dlv = nd;
      m_pend = (clr ? 3'b000 : m_pend) | ev;
    end
  end

  function automatic bit [31:0] mread(input bit [5:0] a);
    case (a)
      6'h00: return {24'h0, m_id};
      6'h04: return m_lo;
      6'h08: return m_hi;
      6'h14: return {8'h0, m_dlv, m_ovf, m_busy};
      6'h18: return {29'h0, m_pend};
      6'h1C: return {29'h0, m_mask};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rtag(input bit [5:0] a);
    case (a)
      6'h00, 6'h04, 6'h08: return "R2";
      6'h14: return "R5";
      6'h18: return "R9";
      6'h1C: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("R8 irq", irq, |(m_pend & ~m_mask));
    check("R3 post_valid", post_valid, m_pv);
    if (m_pv) begin
      check("R3 post_chan", post_chan, m_pc);
      check("R3 post_data", post_data, m_pd);
    end
    check(rtag(bus_addr), bus_rdata, mread(bus_addr));
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
    compare();
  endtask

  task automatic op(input bit we, input bit [5:0] a, input bit [31:0] d,
                    input bit av, input bit [2:0] ac);
    bus_we = we; bus_addr = a; bus_wdata = d; ack_valid = av; ack_chan = ac;
    tick();
    bus_we = 0; ack_valid = 0;
  endtask

  task automatic wr(input bit [5:0] a, input bit [31:0] d);
    op(1, a, d, 0, 0);
  endtask

  task automatic ack(input bit [2:0] c);
    op(0, 6'h14, 0, 1, c);
  endtask

  task automatic rd(input string tag, input bit [5:0] a, input bit [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    rst_n = 1;
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 post_valid", post_valid, 0);
    rd("R1 mask", 6'h1C, 32'h7);
    rd("R1 status", 6'h14, 32'h0);
    rd("R1 pend", 6'h18, 32'h0);
    rd("R1 chan", 6'h00, 32'h0);

    // R2 register hold
    wr(6'h00, 32'h2);
    wr(6'h04, 32'hCAFE_0001);
    wr(6'h08, 32'h1234_5678);
    rd("R2 chan", 6'h00, 32'h2);
    rd("R2 low", 6'h04, 32'hCAFE_0001);
    rd("R2 high", 6'h08, 32'h1234_5678);
    wr(6'h1C, 32'h0);

    // R3 post to idle channel 2
    bus_we = 1; bus_addr = 6'h0C; bus_wdata = 1;
    tick();
    bus_we = 0;
    check("R3 post strobe", post_valid, 1);
    check("R3 post payload", post_data, 64'h1234_5678_CAFE_0001);
    tick();
    check("R3 single pulse", post_valid, 0);
    rd("R3 busy bit", 6'h14, 32'h0000_0004);

    // R4 trigger on busy channel
    wr(6'h0C, 1);
    check("R4 no post", post_valid, 0);
    rd("R4 overflow", 6'h14, 32'h0000_0404);
    rd("R4 pend", 6'h18, 32'h3);
    wr(6'h18, 1);
    wr(6'h0C, 1);
    rd("R4 block only", 6'h18, 32'h1);

    // R5 acknowledge
    ack(3'd2);
    rd("R5 delivered", 6'h14, 32'h0004_0400);
    ack(3'd5);
    rd("R5 stray ack", 6'h14, 32'h0004_0400);
    rd("R5 pend", 6'h18, 32'h5);

    // R7 selective clear
    wr(6'h10, 32'h0004_0000);
    rd("R7 dlv cleared", 6'h14, 32'h0000_0400);
    wr(6'h10, 32'h0000_0400);
    rd("R7 ovf cleared", 6'h14, 32'h0);

    // R6 ignored triggers
    wr(6'h00, 32'h9);
    wr(6'h0C, 1);
    check("R6 no post", post_valid, 0);
    rd("R6 state", 6'h14, 32'h0);
    wr(6'h00, 32'h3);
    wr(6'h0C, 0);
    check("R6 bit0 zero", post_valid, 0);
    rd("R6 state2", 6'h14, 32'h0);

    // R9 clear meets delivery event
    wr(6'h0C, 1);
    wr(6'h18, 1);
    op(1, 6'h18, 1, 1, 3'd3);
    rd("R9 event kept", 6'h18, 32'h4);

    // R8 masking
    wr(6'h1C, 32'h7);
    check("R8 masked", irq, 0);
    wr(6'h1C, 32'h3);
    check("R8 delivery unmasked", irq, 1);

    // R5 trigger and ack on same busy channel in one cycle
    wr(6'h0C, 1);
    op(1, 6'h0C, 1, 1, 3'd3);
    rd("R5 collide", 6'h14, 32'h0008_0800);
    wr(6'h10, 32'h00FF_FF00);
    wr(6'h18, 1);

    // mixed traffic against the model
    for (int n = 0; n < 2000; n++) begin
      int k;
      k = $urandom_range(0, 9);
      case (k)
        0: op(1, 6'h00, $urandom_range(0, 10), 0, 0);
        1: op(1, 6'h04, $urandom, $urandom_range(0, 1), 3'($urandom));
        2: op(1, 6'h08, $urandom, 0, 0);
        3, 4: op(1, 6'h0C, $urandom_range(0, 3), $urandom_range(0, 1), 3'($urandom));
        5: op(1, 6'h10, $urandom, $urandom_range(0, 1), 3'($urandom));
        6: op(1, 6'h18, $urandom_range(0, 1), $urandom_range(0, 1), 3'($urandom));
        7: op(1, 6'h1C, $urandom, 0, 0);
        default: op(0, 6'($urandom_range(0, 7) * 4), 0, 1, 3'($urandom));
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule